// File: doc/BRIEF.md
# Chunked Accelerator Control Shell with Ping-Pong Buffering

This block is the control and buffering logic around a coarse-grained compute kernel. Software first writes a small set of configuration registers: source and destination word offsets, the number of chunks in a dataset, the number of datasets (batches) to run back to back, and a transfer-mode flag. A write with the start bit set then launches the job. The shell issues one read command per chunk and one write command per chunk. Each command goes out on its own control channel, and the data words move on separate load and store data channels. Every channel uses a valid/ready handshake.

Two local chunk buffers work as a ping-pong pair, and three independent engines share them. The loader fills one buffer while the kernel transforms the other and the storer drains whichever buffer is finished. Loading, computing and storing of consecutive chunks therefore overlap. The stand-in kernel maps each word x to 3x+1, modulo 2^32. When the last word of the last chunk of the last batch has been accepted on the store data channel, the shell emits a one-cycle completion pulse that serves as the interrupt and returns to idle.

Top module: `acc_shell`

## Requirements
- R1: After reset, both command valids, the store data valid, the load data ready and `done` are all low. Whenever the shell is idle, no command or store data is offered.
- R2: Configuration writes use these addresses: 0 is control (bit 0 = start), 1 is the source base, 2 is the destination base, 3 is the chunks per batch (bits 15:0), 4 is the batch count (bits 15:0), and 5 is the mode (bit 0 = point-to-point).
- R3: While a command or store data word has valid high and ready low, valid stays high and the payload stays unchanged on the next cycle.
- R4: The store data stream carries 3x+1 (mod 2^32) of every load data word, in arrival order.
- R5: Compute on a buffer starts only after that buffer's load has completed, and a buffer is reloaded only after its store has drained. With the store command channel blocked, exactly two load commands are accepted.
- R6: Chunk k+1 is loaded while chunk k is still being computed or stored. With all readies high, the second load command is accepted before the first store command.
- R7: A job runs chunks × batches chunks in total. Chunk k (counted across batches) uses word offset base + k·CHUNK_WORDS, modulo 2^32.
- R8: Commands are 49 bits wide. Bits 31:0 hold the word offset, bits 47:32 hold the length (CHUNK_WORDS), and bit 48 is the point-to-point flag, which copies mode bit 0 on both command channels.
- R9: `done` is a single-cycle pulse, one per job, raised after the final store data handshake. A job with zero total chunks pulses `done` without issuing any command.
- R10: While a job runs, register writes and start requests are ignored. The running job keeps its offsets and is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| ld_cmd_valid | output | 1 | Load command offered |
| ld_cmd_ready | input | 1 | Load command accepted |
| ld_cmd_data | output | 49 | Load command {p2p, length, offset} |
| ld_data_valid | input | 1 | Load data word offered |
| ld_data_ready | output | 1 | Shell accepts load data |
| ld_data | input | 32 | Load data word |
| st_cmd_valid | output | 1 | Store command offered |
| st_cmd_ready | input | 1 | Store command accepted |
| st_cmd_data | output | 49 | Store command {p2p, length, offset} |
| st_data_valid | output | 1 | Store data word offered |
| st_data_ready | input | 1 | Store data accepted |
| st_data | output | 32 | Store data word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The main function is tried with a table of jobs covering several patterns:
- A single chunk, which separates the start-up and completion paths from steady-state streaming.
- Multi-chunk, multi-batch jobs, which show whether offsets keep advancing across batch boundaries.
- Jobs in point-to-point mode, which show that the flag reaches both command channels.
- Data seeds near 2^32 and offsets that wrap, which expose width and carry errors.

Jobs run either with every ready held high or with pseudo-random valid/ready gaps on all channels; the random pattern is what exposes payloads that change under backpressure. Directed cases then cover a zero-length job, writes and starts issued while busy, and a blocked store command channel that shows whether buffers are recycled too early.

// File: rtl/acc_shell_pkg.sv
package acc_shell_pkg;

    localparam int DATA_W  = 32;
    localparam int OFF_W   = 32;
    localparam int LEN_W   = 16;
    localparam int CNT_W   = 16;
    localparam int RADDR_W = 3;

    localparam logic [RADDR_W-1:0] RA_CTRL = 3'd0;
    localparam logic [RADDR_W-1:0] RA_SRC  = 3'd1;
    localparam logic [RADDR_W-1:0] RA_DST  = 3'd2;
    localparam logic [RADDR_W-1:0] RA_NCH  = 3'd3;
    localparam logic [RADDR_W-1:0] RA_NBT  = 3'd4;
    localparam logic [RADDR_W-1:0] RA_MODE = 3'd5;

    typedef struct packed {
        logic             p2p;
        logic [LEN_W-1:0] len;
        logic [OFF_W-1:0] off;
    } xfer_cmd_t;

    localparam int CMD_W = $bits(xfer_cmd_t);

    typedef struct packed {
        logic [OFF_W-1:0] src_base;
        logic [OFF_W-1:0] dst_base;
        logic [CNT_W-1:0] n_chunk;
        logic [CNT_W-1:0] n_batch;
        logic             p2p;
    } shell_cfg_t;

    typedef enum logic [1:0] {PB_FREE, PB_FULL, PB_DONE} pbuf_st_t;
    typedef enum logic [1:0] {XS_IDLE, XS_CMD, XS_DATA} xfer_st_t;
    typedef enum logic [1:0] {KS_IDLE, KS_WAIT, KS_RUN} kern_st_t;

    // Stand-in compute function: 3x + 1, wrapping.
    function automatic logic [DATA_W-1:0] kernel_fn(input logic [DATA_W-1:0] x);
        return (x << 1) + x + DATA_W'(1);
    endfunction

    function automatic logic [OFF_W-1:0] chunk_off(input logic [OFF_W-1:0] base,
                                                   input logic [OFF_W-1:0] k,
                                                   input int               words);
        return base + k * OFF_W'(words);
    endfunction

endpackage

// File: rtl/shell_regs.sv
module shell_regs
    import acc_shell_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [RADDR_W-1:0] addr,
    input  logic [31:0]        wdata,
    input  logic               busy,
    output shell_cfg_t         cfg,
    output logic               go
);

    assign go = we && !busy && (addr == RA_CTRL) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we && !busy) begin
            case (addr)
                RA_SRC:  cfg.src_base <= wdata;
                RA_DST:  cfg.dst_base <= wdata;
                RA_NCH:  cfg.n_chunk  <= wdata[CNT_W-1:0];
                RA_NBT:  cfg.n_batch  <= wdata[CNT_W-1:0];
                RA_MODE: cfg.p2p      <= wdata[0];
                default: ;
            endcase
        end
    end

    // R10: configuration frozen while a job is running
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));

endmodule

// File: rtl/shell_loader.sv
module shell_loader
    import acc_shell_pkg::*;
#(
    parameter int CHUNK_WORDS = 8,
    localparam int IW = $clog2(CHUNK_WORDS)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [31:0]       total,
    input  logic [OFF_W-1:0]  base,
    input  logic              p2p,
    input  logic [1:0]        buf_free,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output xfer_cmd_t         cmd_data,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [DATA_W-1:0] dat,
    output logic              wr_en,
    output logic              wr_buf,
    output logic [IW-1:0]     wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              filled
);

    xfer_st_t    st;
    logic [31:0] k;
    logic [IW-1:0] idx;
    logic        last;

    assign last      = (idx == IW'(CHUNK_WORDS - 1));
    assign cmd_valid = (st == XS_CMD) && buf_free[k[0]];
    assign cmd_data  = '{p2p: p2p, len: LEN_W'(CHUNK_WORDS), off: chunk_off(base, k, CHUNK_WORDS)};
    assign dat_ready = (st == XS_DATA);
    assign wr_en     = dat_ready && dat_valid;
    assign wr_buf    = k[0];
    assign wr_idx    = idx;
    assign wr_data   = dat;
    assign filled    = wr_en && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= XS_IDLE;
            k   <= '0;
            idx <= '0;
        end else if (go) begin
            k   <= '0;
            idx <= '0;
            st  <= (total != 0) ? XS_CMD : XS_IDLE;
        end else begin
            case (st)
                XS_CMD: if (cmd_valid && cmd_ready) begin
                    st  <= XS_DATA;
                    idx <= '0;
                end
                XS_DATA: if (dat_valid) begin
                    idx <= idx + 1'b1;
                    if (last) begin
                        idx <= '0;
                        k   <= k + 1;
                        st  <= (k + 1 == total) ? XS_IDLE : XS_CMD;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: load command held under backpressure
    a_r3_ld_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

endmodule

// File: rtl/shell_kernel.sv
module shell_kernel
    import acc_shell_pkg::*;
#(
    parameter int CHUNK_WORDS = 8,
    localparam int IW = $clog2(CHUNK_WORDS)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [31:0]       total,
    input  logic [1:0]        buf_full,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sel,
    output logic [IW-1:0]     idx,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              finished
);

    kern_st_t    st;
    logic [31:0] k;
    logic        last;

    assign sel      = k[0];
    assign last     = (idx == IW'(CHUNK_WORDS - 1));
    assign wr_en    = (st == KS_RUN);
    assign wr_data  = kernel_fn(rd_data);
    assign finished = wr_en && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= KS_IDLE;
            k   <= '0;
            idx <= '0;
        end else if (go) begin
            k   <= '0;
            idx <= '0;
            st  <= (total != 0) ? KS_WAIT : KS_IDLE;
        end else begin
            case (st)
                KS_WAIT: if (buf_full[k[0]]) begin
                    st  <= KS_RUN;
                    idx <= '0;
                end
                KS_RUN: begin
                    idx <= idx + 1'b1;
                    if (last) begin
                        idx <= '0;
                        k   <= k + 1;
                        st  <= (k + 1 == total) ? KS_IDLE : KS_WAIT;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/shell_storer.sv
module shell_storer
    import acc_shell_pkg::*;
#(
    parameter int CHUNK_WORDS = 8,
    localparam int IW = $clog2(CHUNK_WORDS)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [31:0]       total,
    input  logic [OFF_W-1:0]  base,
    input  logic              p2p,
    input  logic [1:0]        buf_done,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output xfer_cmd_t         cmd_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sel,
    output logic [IW-1:0]     idx,
    output logic              dat_valid,
    input  logic              dat_ready,
    output logic [DATA_W-1:0] dat,
    output logic              drained,
    output logic              job_end
);

    xfer_st_t    st;
    logic [31:0] k;
    logic        last;

    assign sel       = k[0];
    assign last      = (idx == IW'(CHUNK_WORDS - 1));
    assign cmd_valid = (st == XS_CMD) && buf_done[k[0]];
    assign cmd_data  = '{p2p: p2p, len: LEN_W'(CHUNK_WORDS), off: chunk_off(base, k, CHUNK_WORDS)};
    assign dat_valid = (st == XS_DATA);
    assign dat       = rd_data;
    assign drained   = dat_valid && dat_ready && last;
    assign job_end   = drained && (k + 1 == total);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= XS_IDLE;
            k   <= '0;
            idx <= '0;
        end else if (go) begin
            k   <= '0;
            idx <= '0;
            st  <= (total != 0) ? XS_CMD : XS_IDLE;
        end else begin
            case (st)
                XS_CMD: if (cmd_valid && cmd_ready) begin
                    st  <= XS_DATA;
                    idx <= '0;
                end
                XS_DATA: if (dat_ready) begin
                    idx <= idx + 1'b1;
                    if (last) begin
                        idx <= '0;
                        k   <= k + 1;
                        st  <= (k + 1 == total) ? XS_IDLE : XS_CMD;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: store command and store data held under backpressure
    a_r3_st_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));
    a_r3_st_data_hold: assert property (@(posedge clk) disable iff (rst)
        dat_valid && !dat_ready |=> dat_valid && $stable(dat));

endmodule

// File: rtl/acc_shell.sv
module acc_shell
    import acc_shell_pkg::*;
#(
    parameter int CHUNK_WORDS = 8,
    localparam int IW = $clog2(CHUNK_WORDS)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [RADDR_W-1:0] cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic               ld_cmd_valid,
    input  logic               ld_cmd_ready,
    output logic [CMD_W-1:0]   ld_cmd_data,
    input  logic               ld_data_valid,
    output logic               ld_data_ready,
    input  logic [DATA_W-1:0]  ld_data,
    output logic               st_cmd_valid,
    input  logic               st_cmd_ready,
    output logic [CMD_W-1:0]   st_cmd_data,
    output logic               st_data_valid,
    input  logic               st_data_ready,
    output logic [DATA_W-1:0]  st_data,
    output logic               done
);

    shell_cfg_t  cfg;
    logic        go, run, done_q;
    logic [31:0] total;
    pbuf_st_t    bstat [2];
    logic [1:0]  is_free, is_full, is_done;
    logic [DATA_W-1:0] pp_mem [2][CHUNK_WORDS];

    xfer_cmd_t         ld_cmd, st_cmd;
    logic              ld_we, ld_buf, ld_filled;
    logic [IW-1:0]     ld_idx;
    logic [DATA_W-1:0] ld_wdata;
    logic              cp_sel, cp_we, cp_fin;
    logic [IW-1:0]     cp_idx;
    logic [DATA_W-1:0] cp_wdata;
    logic              sr_sel, sr_drained, sr_end;
    logic [IW-1:0]     sr_idx;

    assign total       = 32'(cfg.n_chunk) * 32'(cfg.n_batch);
    assign ld_cmd_data = ld_cmd;
    assign st_cmd_data = st_cmd;
    assign done        = done_q;

    for (genvar b = 0; b < 2; b++) begin : g_flags
        assign is_free[b] = (bstat[b] == PB_FREE);
        assign is_full[b] = (bstat[b] == PB_FULL);
        assign is_done[b] = (bstat[b] == PB_DONE);
    end

    shell_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .busy(run), .cfg(cfg), .go(go)
    );

    shell_loader #(.CHUNK_WORDS(CHUNK_WORDS)) u_loader (
        .clk(clk), .rst(rst), .go(go), .total(total),
        .base(cfg.src_base), .p2p(cfg.p2p), .buf_free(is_free),
        .cmd_valid(ld_cmd_valid), .cmd_ready(ld_cmd_ready), .cmd_data(ld_cmd),
        .dat_valid(ld_data_valid), .dat_ready(ld_data_ready), .dat(ld_data),
        .wr_en(ld_we), .wr_buf(ld_buf), .wr_idx(ld_idx), .wr_data(ld_wdata),
        .filled(ld_filled)
    );

    shell_kernel #(.CHUNK_WORDS(CHUNK_WORDS)) u_kernel (
        .clk(clk), .rst(rst), .go(go), .total(total), .buf_full(is_full),
        .rd_data(pp_mem[cp_sel][cp_idx]), .sel(cp_sel), .idx(cp_idx),
        .wr_en(cp_we), .wr_data(cp_wdata), .finished(cp_fin)
    );

    shell_storer #(.CHUNK_WORDS(CHUNK_WORDS)) u_storer (
        .clk(clk), .rst(rst), .go(go), .total(total),
        .base(cfg.dst_base), .p2p(cfg.p2p), .buf_done(is_done),
        .cmd_valid(st_cmd_valid), .cmd_ready(st_cmd_ready), .cmd_data(st_cmd),
        .rd_data(pp_mem[sr_sel][sr_idx]), .sel(sr_sel), .idx(sr_idx),
        .dat_valid(st_data_valid), .dat_ready(st_data_ready), .dat(st_data),
        .drained(sr_drained), .job_end(sr_end)
    );

    // Buffer storage: loader and kernel always address different buffers.
    always_ff @(posedge clk) begin
        if (ld_we) pp_mem[ld_buf][ld_idx] <= ld_wdata;
        if (cp_we) pp_mem[cp_sel][cp_idx] <= cp_wdata;
    end

    // Buffer ownership: each transition requires a distinct current state.
    always_ff @(posedge clk) begin
        if (rst || go) begin
            bstat[0] <= PB_FREE;
            bstat[1] <= PB_FREE;
        end else begin
            if (ld_filled)  bstat[ld_buf] <= PB_FULL;
            if (cp_fin)     bstat[cp_sel] <= PB_DONE;
            if (sr_drained) bstat[sr_sel] <= PB_FREE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= sr_end || (go && total == 0);
            if (go && total != 0) run <= 1'b1;
            else if (sr_end)      run <= 1'b0;
        end
    end

    // R1: nothing offered while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !run |-> !ld_cmd_valid && !st_cmd_valid && !st_data_valid);
    // R5: buffer ownership ordering
    a_r5_load_into_free: assert property (@(posedge clk) disable iff (rst)
        ld_we |-> bstat[ld_buf] == PB_FREE);
    a_r5_compute_on_full: assert property (@(posedge clk) disable iff (rst)
        cp_we |-> bstat[cp_sel] == PB_FULL);
    a_r5_store_from_done: assert property (@(posedge clk) disable iff (rst)
        st_data_valid |-> bstat[sr_sel] == PB_DONE);
    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/test_acc_shell.sv
module test_acc_shell;
    import acc_shell_pkg::*;

    localparam int CW = 8;

    typedef struct packed {
        logic [15:0] nch;
        logic [15:0] nbt;
        logic        p2p;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] seed;
        logic [1:0]  mode;
    } job_t;

    localparam job_t JOBS [5] = '{
        '{16'd1, 16'd1, 1'b0, 32'h0000_0100, 32'h0000_2000, 32'h0000_0000, 2'd0},
        '{16'd3, 16'd1, 1'b0, 32'h0000_0040, 32'h0000_4000, 32'h0000_0010, 2'd1},
        '{16'd2, 16'd3, 1'b1, 32'h0000_0000, 32'h0000_0100, 32'hFFFF_FFF0, 2'd1},
        '{16'd4, 16'd2, 1'b1, 32'h0000_1000, 32'h0000_9000, 32'h0000_1234, 2'd0},
        '{16'd1, 16'd4, 1'b0, 32'hFFFF_FFF0, 32'h0000_0000, 32'h0000_0007, 2'd1}
    };

    logic clk = 0, rst = 1;
    logic cfg_we = 0;
    logic [2:0] cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic ld_cmd_valid, ld_cmd_ready = 0;
    logic [CMD_W-1:0] ld_cmd_data;
    logic ld_data_valid = 0, ld_data_ready;
    logic [31:0] ld_data = 0;
    logic st_cmd_valid, st_cmd_ready = 0;
    logic [CMD_W-1:0] st_cmd_data;
    logic st_data_valid, st_data_ready = 0;
    logic [31:0] st_data;
    logic done;

    always #2 clk = ~clk;

    acc_shell #(.CHUNK_WORDS(CW)) i_acc_shell (.*);

    int n_chk = 0, n_fail = 0;
    // job description, driven only by the initial block
    int job_no = 0;
    logic [15:0] j_nch, j_nbt;
    logic j_p2p;
    logic [31:0] j_src, j_dst, j_seed;
    logic [1:0] j_mode = 0;
    // monitor state, driven only by the negedge block
    int seen_job = 0, cyc = 0;
    int src_n = 0, ld_cnt = 0, st_cnt = 0, st_w = 0, done_cnt = 0;
    int t_ld1 = 0, t_st0 = 0;
    bit src_pend = 0, hold_pend = 0;
    logic [31:0] held = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [48:0] exp_cmd(input logic [31:0] base, input int k);
        return {j_p2p, 16'(CW), base + 32'(k) * 32'(CW)};
    endfunction

    always @(negedge clk) if (!rst) begin
        cyc++;
        if (job_no != seen_job) begin
            seen_job = job_no;
            src_n = 0; ld_cnt = 0; st_cnt = 0; st_w = 0; done_cnt = 0;
            src_pend = 0; hold_pend = 0;
        end
        // load data source
        if (src_pend) src_n++;
        ld_data_valid = (j_mode == 1) ? lfsr[0] : 1'b1;
        ld_data = j_seed + 32'(src_n);
        src_pend = ld_data_valid && ld_data_ready;
        // load command sink (R7, R8)
        ld_cmd_ready = (j_mode == 1) ? lfsr[1] : 1'b1;
        if (ld_cmd_valid && ld_cmd_ready) begin
            chk(ld_cmd_data == exp_cmd(j_src, ld_cnt), "R7/R8", "load cmd",
                64'(ld_cmd_data), 64'(exp_cmd(j_src, ld_cnt)));
            if (ld_cnt == 1) t_ld1 = cyc;
            ld_cnt++;
        end
        // store command sink (R7, R8)
        st_cmd_ready = (j_mode == 2) ? 1'b0 : (j_mode == 1) ? lfsr[2] : 1'b1;
        if (st_cmd_valid && st_cmd_ready) begin
            chk(st_cmd_data == exp_cmd(j_dst, st_cnt), "R7/R8", "store cmd",
                64'(st_cmd_data), 64'(exp_cmd(j_dst, st_cnt)));
            if (st_cnt == 0) t_st0 = cyc;
            st_cnt++;
        end
        // store data sink (R3, R4)
        if (hold_pend)
            chk(st_data_valid && st_data == held, "R3", "store data held",
                64'(st_data), 64'(held));
        st_data_ready = (j_mode == 1) ? lfsr[3] : 1'b1;
        if (st_data_valid && st_data_ready) begin
            chk(st_data == (j_seed + 32'(st_w)) * 32'd3 + 32'd1, "R4", "store word",
                64'(st_data), 64'((j_seed + 32'(st_w)) * 32'd3 + 32'd1));
            st_w++;
        end
        hold_pend = st_data_valid && !st_data_ready;
        held = st_data;
        if (done) done_cnt++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic start_job(input job_t j);
        @(posedge clk); #1;
        j_nch = j.nch; j_nbt = j.nbt; j_p2p = j.p2p;
        j_src = j.src; j_dst = j.dst; j_seed = j.seed; j_mode = j.mode;
        job_no++;
        wr(RA_SRC, j.src);
        wr(RA_DST, j.dst);
        wr(RA_NCH, 32'(j.nch));
        wr(RA_NBT, 32'(j.nbt));
        wr(RA_MODE, 32'(j.p2p));
        wr(RA_CTRL, 32'h1);
    endtask

    task automatic finish_job(input string tag);
        int tot;
        tot = int'(j_nch) * int'(j_nbt);
        for (int i = 0; i < 6000 && done_cnt == 0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(done_cnt == 1, "R9", {tag, " done pulses"}, 64'(done_cnt), 64'd1);
        chk(ld_cnt == tot, "R7", {tag, " load cmds"}, 64'(ld_cnt), 64'(tot));
        chk(st_cnt == tot, "R7", {tag, " store cmds"}, 64'(st_cnt), 64'(tot));
        chk(st_w == tot * CW, "R4", {tag, " store words"}, 64'(st_w), 64'(tot * CW));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(!ld_cmd_valid && !st_cmd_valid && !st_data_valid, "R1", "valids after reset",
            {61'd0, ld_cmd_valid, st_cmd_valid, st_data_valid}, 64'd0);
        chk(!ld_data_ready && !done, "R1", "ready/done after reset",
            {62'd0, ld_data_ready, done}, 64'd0);

        // table-driven jobs (R2, R3, R4, R7, R8, R9)
        for (int r = 0; r < 5; r++) begin
            start_job(JOBS[r]);
            finish_job($sformatf("job%0d", r));
        end

        // R6: overlap, all readies high
        start_job('{16'd3, 16'd1, 1'b0, 32'h10, 32'h20, 32'h5, 2'd0});
        finish_job("R6 job");
        chk(t_ld1 < t_st0, "R6", "second load before first store", 64'(t_ld1), 64'(t_st0));

        // R9: zero-length job
        start_job('{16'd0, 16'd5, 1'b0, 32'h0, 32'h0, 32'h0, 2'd0});
        finish_job("R9 zero");

        // R10: writes and start while busy are ignored
        start_job('{16'd3, 16'd2, 1'b1, 32'h300, 32'h600, 32'h9, 2'd1});
        repeat (5) @(negedge clk);
        wr(RA_SRC, 32'hDEAD_0000);
        wr(RA_MODE, 32'h0);
        wr(RA_CTRL, 32'h1);
        finish_job("R10 busy");

        // R5: blocked store command channel limits loads to two buffers
        start_job('{16'd4, 16'd1, 1'b0, 32'h80, 32'h800, 32'h33, 2'd2});
        repeat (300) @(negedge clk);
        chk(ld_cnt == 2, "R5", "loads with store blocked", 64'(ld_cnt), 64'd2);
        chk(st_w == 0, "R5", "store words while blocked", 64'(st_w), 64'd0);
        @(posedge clk); #1;
        j_mode = 0;
        finish_job("R5 release");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule